// File: doc/BRIEF.md
# Cross-Thread Software Interrupt Register Unit

This unit holds one 64-bit pending-interrupt vector per hardware thread and gives software three registers, each selected by its own address-space identifier, to send, inspect and retire interrupts between threads. Through the receive register a thread reads its whole vector or acknowledges a group of bits with a write mask. Through the incoming-vector register it pops its highest pending interrupt number. Through the dispatch register it posts an interrupt number to any thread. Each thread also drives a level output that tells the trap logic something is pending.

Every access is checked against the requester's privilege level and against the direction each register permits. A rejected access returns a fault code and no data, changes no vector, and fills a fault status record. Requests come in one per cycle. The unit answers each one on the next cycle.

Top module: `xirq_unit`

## Requirements
- R1: After reset every vector is zero, every `irqPending` bit is 0, `rspValid` is 0 and `fsrValid` is 0.
- R2: A read of the receive space (`reqSpace` = `SP_RECV`, default 8'h40) returns the accessing thread's full 64-bit vector on `rspData` and leaves the vector unchanged.
- R3: A read of the incoming space (`SP_INVEC`, default 8'h41) returns the index of the highest set pending bit, zero-extended, and clears only that bit. When nothing is pending it returns 0 and changes nothing.
- R4: A write of the receive space clears every pending bit of the accessing thread that is set in `reqWdata` and keeps the others.
- R5: A write of the dispatch space (`SP_DISP`, default 8'h42) sets bit `reqWdata[5:0]` in the thread numbered `reqWdata[12:8]`. A target number at or above `NTHREADS` is ignored.
- R6: An access that is not hyperprivileged (`reqHpriv`=0) is rejected and changes no vector. `rspFault` is 1 (data-access) when `reqPriv`=1 and 2 (privileged-action) when `reqPriv`=0.
- R7: A hyperprivileged write of the incoming space or read of the dispatch space is rejected with `rspFault` = 1 (data-access).
- R8: Each rejected access loads the fault status record: `fsrValid`=1, `fsrAddr` = the request address, `fsrWrite` = the direction, `fsrCtx` = 0 (primary), `fsrCause` = 1 (illegal address space), `fsrSpace` = the request's space identifier.
- R9: `irqPending[t]` is the OR of thread t's 64 vector bits. It follows the vector one cycle after the vector register changes.
- R10: A request to one of the three spaces gets `rspValid`=1 on the cycle after it is presented, with `rspFault`=0 and `rspData`=0 for accepted writes. A request to any other space gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqThread | input | THREAD_W | Accessing thread number |
| reqSpace | input | 8 | Address-space identifier of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqHpriv | input | 1 | Requester is hyperprivileged |
| reqPriv | input | 1 | Requester is privileged |
| reqAddr | input | ADDR_W | Virtual address of the access |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspFault | output | 2 | 0 none, 1 data-access, 2 privileged-action |
| rspData | output | 64 | Read result |
| fsrValid | output | 1 | Fault record holds a fault |
| fsrAddr | output | ADDR_W | Faulting address |
| fsrWrite | output | 1 | Faulting direction |
| fsrCtx | output | 2 | Context, 0 = primary |
| fsrCause | output | 2 | Fault cause, 1 = illegal address space |
| fsrSpace | output | 8 | Faulting space identifier |
| irqPending | output | NTHREADS | Per-thread interrupt pending level |

## Verification
Responses, fault codes, the fault record and vector updates all take effect at the first rising edge after a request. The per-thread pending output appears one edge after that. The bench drives each request on a falling edge and drops it at the next falling edge, where it samples the response and the record. It waits one more falling edge before it compares `irqPending`. State that an access must leave alone is read back afterwards through the receive register, so every check observes a result only at the cycle when that result is due.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DATA = 2'd1,
    FLT_PRIV = 2'd2
  } fault_e;

  localparam logic [1:0] CAUSE_ILLEGAL_SPACE = 2'd1;
  localparam logic [1:0] CTX_PRIMARY = 2'd0;

  typedef struct packed {
    logic       readAll;
    logic       popMsb;
    logic       clearMask;
    logic       post;
    logic [4:0] thread;
  } strobe_t;
endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NTHREADS = 8,
  parameter int ADDR_W = 48,
  parameter logic [7:0] SP_RECV = 8'h40,
  parameter logic [7:0] SP_INVEC = 8'h41,
  parameter logic [7:0] SP_DISP = 8'h42,
  localparam int THREAD_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [THREAD_W-1:0] reqThread,
  input  logic [7:0]          reqSpace,
  input  logic                reqWrite,
  input  logic                reqHpriv,
  input  logic                reqPriv,
  input  logic [ADDR_W-1:0]   reqAddr,
  output strobe_t             stb,
  output logic                rspValid,
  output fault_e              rspFault,
  output logic                fsrValid,
  output logic [ADDR_W-1:0]   fsrAddr,
  output logic                fsrWrite,
  output logic [1:0]          fsrCtx,
  output logic [1:0]          fsrCause,
  output logic [7:0]          fsrSpace
);
  logic isRecv, isInvec, isDisp, hit, privBad, dirBad, reject, threadOk;
  fault_e faultNow;

  assign isRecv   = reqSpace == SP_RECV;
  assign isInvec  = reqSpace == SP_INVEC;
  assign isDisp   = reqSpace == SP_DISP;
  assign hit      = reqValid && (isRecv || isInvec || isDisp);
  assign privBad  = !reqHpriv;
  assign dirBad   = (isInvec && reqWrite) || (isDisp && !reqWrite);
  assign reject   = hit && (privBad || dirBad);
  assign threadOk = int'(reqThread) < NTHREADS;

  always_comb begin
    faultNow = FLT_NONE;
    if (reject) faultNow = (privBad && !reqPriv) ? FLT_PRIV : FLT_DATA;
  end

  always_comb begin
    stb = '0;
    stb.thread = 5'(reqThread);
    if (hit && !reject && threadOk) begin
      stb.readAll   = isRecv && !reqWrite;
      stb.clearMask = isRecv && reqWrite;
      stb.popMsb    = isInvec;
      stb.post      = isDisp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
      fsrValid <= 1'b0;
      fsrAddr  <= '0;
      fsrWrite <= 1'b0;
      fsrCtx   <= CTX_PRIMARY;
      fsrCause <= '0;
      fsrSpace <= '0;
    end else begin
      rspValid <= hit;
      rspFault <= faultNow;
      if (reject) begin
        fsrValid <= 1'b1;
        fsrAddr  <= reqAddr;
        fsrWrite <= reqWrite;
        fsrCtx   <= CTX_PRIMARY;
        fsrCause <= CAUSE_ILLEGAL_SPACE;
        fsrSpace <= reqSpace;
      end
    end
  end

  // R6: non-hyperprivileged requests always come back faulted
  p_reject_unpriv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !reqHpriv) |=> (rspValid && rspFault != FLT_NONE));

  // R7: writing the read-only incoming space is a data-access fault
  p_dir_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && reqHpriv && isInvec && reqWrite) |=> (rspFault == FLT_DATA));

  // R8: a rejected access fills the record with its address
  p_record_r8: assert property (@(posedge clk) disable iff (!rstN)
    reject |=> (fsrValid && fsrAddr == $past(reqAddr) && fsrSpace == $past(reqSpace)));

  // R10: requests outside the three spaces get no response
  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> !rspValid);
endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NTHREADS = 8,
  localparam int THREAD_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [63:0]         wdata,
  output logic [63:0]         rspData,
  output logic [NTHREADS-1:0] irqPending
);
  logic [NTHREADS-1:0][63:0] vecQ, vecNext;
  logic [63:0] selVec;
  logic [5:0]  selMsb;
  logic        selAny, postOk;
  logic [4:0]  postTgt;
  logic [5:0]  postBit;

  assign postTgt = wdata[12:8];
  assign postBit = wdata[5:0];
  assign postOk  = stb.post && (int'(postTgt) < NTHREADS);

  always_comb begin
    selVec = '0;
    if (int'(stb.thread) < NTHREADS) selVec = vecQ[stb.thread[THREAD_W-1:0]];
  end

  always_comb begin
    selMsb = '0;
    for (int i = 0; i < 64; i++) begin
      if (selVec[i]) selMsb = 6'(i);
    end
  end
  assign selAny = |selVec;

  always_comb begin
    for (int t = 0; t < NTHREADS; t++) begin
      vecNext[t] = vecQ[t];
      if (int'(stb.thread) == t) begin
        if (stb.clearMask) vecNext[t] = vecNext[t] & ~wdata;
        if (stb.popMsb && selAny) vecNext[t][selMsb] = 1'b0;
      end
      if (postOk && int'(postTgt) == t) vecNext[t][postBit] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ       <= '0;
      irqPending <= '0;
      rspData    <= '0;
    end else begin
      vecQ <= vecNext;
      for (int t = 0; t < NTHREADS; t++) irqPending[t] <= |vecQ[t];
      if (stb.readAll)     rspData <= selVec;
      else if (stb.popMsb) rspData <= {58'b0, selMsb};
      else                 rspData <= '0;
    end
  end

  // R2: reading the receive register reports the vector it saw
  p_recv_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readAll && !stb.post) |=> (rspData == $past(selVec) && $stable(vecQ)));

  // R3: a pop result is always a 6-bit index
  p_pop_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.popMsb |=> (rspData[63:6] == '0));

  for (genvar t = 0; t < NTHREADS; t++) begin : g_chk
    // R5: an accepted dispatch always lands, even against a clear
    p_post_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
      (postOk && int'(postTgt) == t) |=> vecQ[t][$past(postBit)]);
    // R9: pending level trails the vector by one cycle
    p_pend_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (irqPending[t] == (|$past(vecQ[t]))));
  end
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int NTHREADS = 8,
  parameter int ADDR_W = 48,
  parameter logic [7:0] SP_RECV = 8'h40,
  parameter logic [7:0] SP_INVEC = 8'h41,
  parameter logic [7:0] SP_DISP = 8'h42,
  localparam int THREAD_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [THREAD_W-1:0] reqThread,
  input  logic [7:0]          reqSpace,
  input  logic                reqWrite,
  input  logic                reqHpriv,
  input  logic                reqPriv,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [63:0]         reqWdata,
  output logic                rspValid,
  output logic [1:0]          rspFault,
  output logic [63:0]         rspData,
  output logic                fsrValid,
  output logic [ADDR_W-1:0]   fsrAddr,
  output logic                fsrWrite,
  output logic [1:0]          fsrCtx,
  output logic [1:0]          fsrCause,
  output logic [7:0]          fsrSpace,
  output logic [NTHREADS-1:0] irqPending
);
  strobe_t stb;
  fault_e  faultQ;

  xirq_ctrl #(
    .NTHREADS(NTHREADS), .ADDR_W(ADDR_W),
    .SP_RECV(SP_RECV), .SP_INVEC(SP_INVEC), .SP_DISP(SP_DISP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqSpace(reqSpace), .reqWrite(reqWrite), .reqHpriv(reqHpriv),
    .reqPriv(reqPriv), .reqAddr(reqAddr), .stb(stb), .rspValid(rspValid),
    .rspFault(faultQ), .fsrValid(fsrValid), .fsrAddr(fsrAddr),
    .fsrWrite(fsrWrite), .fsrCtx(fsrCtx), .fsrCause(fsrCause),
    .fsrSpace(fsrSpace)
  );

  xirq_datapath #(.NTHREADS(NTHREADS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .rspData(rspData), .irqPending(irqPending)
  );

  assign rspFault = faultQ;
endmodule

// File: tb/sim_xirq_unit.sv
`timescale 1ns/1ps
module sim_xirq_unit;
  localparam int N = 8;
  localparam logic [7:0] RECV = 8'h40, INVEC = 8'h41, DISP = 8'h42;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqHpriv = 1'b0, reqPriv = 1'b0;
  logic [2:0]  reqThread = '0;
  logic [7:0]  reqSpace = '0;
  logic [47:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic rspValid, fsrValid, fsrWrite;
  logic [1:0] rspFault, fsrCtx, fsrCause;
  logic [63:0] rspData;
  logic [47:0] fsrAddr;
  logic [7:0] fsrSpace;
  logic [N-1:0] irqPending;
  int checks = 0, errors = 0;
  logic gotV; logic [1:0] gotF; logic [63:0] gotD;

  always #4 clk = ~clk;

  xirq_unit #(.NTHREADS(N)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input int th, input logic [7:0] sp, input bit wr, input bit hp,
                     input bit pv, input logic [63:0] d, input logic [47:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqThread = 3'(th); reqSpace = sp; reqWrite = wr;
    reqHpriv = hp; reqPriv = pv; reqWdata = d; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    gotV = rspValid; gotF = rspFault; gotD = rspData;
  endtask

  function automatic logic [63:0] dsp(input int th, input int b);
    return 64'((th << 8) | b);
  endfunction

  task automatic tReset;
    chk(rspValid == 0 && fsrValid == 0, "R1 rsp/fsr idle", {62'b0, rspValid, fsrValid}, 0);
    chk(irqPending == 0, "R1 pending", 64'(irqPending), 0);
  endtask

  task automatic tDispatchRead;
    acc(0, DISP, 1, 1, 1, dsp(2, 5), 48'h100);
    chk(gotV && gotF == 0 && gotD == 0, "R10 write response", {gotV, 1'b0, gotF, gotD[59:0]}, 64'h8000_0000_0000_0000);
    acc(0, DISP, 1, 1, 1, dsp(2, 63), 48'h100);
    acc(1, DISP, 1, 1, 1, dsp(2, 0), 48'h100);
    chk(irqPending == 8'b0000_0100, "R9 pending after dispatch", 64'(irqPending), 64'h4);
    acc(2, RECV, 0, 1, 1, 0, 48'h0);
    chk(gotV && gotD == 64'h8000_0000_0000_0021, "R2 receive read", gotD, 64'h8000_0000_0000_0021);
    acc(2, RECV, 0, 1, 1, 0, 48'h0);
    chk(gotD == 64'h8000_0000_0000_0021, "R2 receive read unchanged", gotD, 64'h8000_0000_0000_0021);
  endtask

  task automatic tPop;
    acc(2, INVEC, 0, 1, 1, 0, 0);
    chk(gotV && gotF == 0 && gotD == 63, "R3 pop highest", gotD, 63);
    acc(2, INVEC, 0, 1, 1, 0, 0);
    chk(gotD == 5, "R3 pop next", gotD, 5);
    acc(2, INVEC, 0, 1, 1, 0, 0);
    chk(gotD == 0, "R3 pop bit zero", gotD, 0);
    acc(2, INVEC, 0, 1, 1, 0, 0);
    chk(gotV && gotD == 0, "R3 pop empty", gotD, 0);
    @(negedge clk);
    chk(irqPending == 0, "R9 pending cleared", 64'(irqPending), 0);
    acc(2, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 0, "R3 vector empty after pops", gotD, 0);
  endtask

  task automatic tClear;
    acc(0, DISP, 1, 1, 1, dsp(3, 1), 0);
    acc(0, DISP, 1, 1, 1, dsp(3, 2), 0);
    acc(0, DISP, 1, 1, 1, dsp(3, 3), 0);
    acc(3, RECV, 1, 1, 1, 64'h6, 0);
    chk(gotV && gotF == 0 && gotD == 0, "R4 clear response", gotD, 0);
    acc(3, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 64'h8, "R4 masked clear", gotD, 64'h8);
  endtask

  task automatic tRange;
    acc(0, DISP, 1, 1, 1, dsp(9, 7), 0);
    @(negedge clk);
    chk(irqPending == 8'b0000_1000, "R5 out-of-range target ignored", 64'(irqPending), 64'h8);
    acc(1, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 0, "R5 thread 1 untouched", gotD, 0);
  endtask

  task automatic tPriv;
    acc(4, RECV, 0, 0, 1, 0, 48'h1234);
    chk(gotV && gotF == 1 && gotD == 0, "R6 privileged -> data-access", 64'(gotF), 1);
    acc(4, DISP, 1, 0, 0, dsp(4, 9), 48'h2222);
    chk(gotV && gotF == 2, "R6 user -> privileged-action", 64'(gotF), 2);
    acc(4, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 0, "R6 rejected dispatch had no effect", gotD, 0);
    acc(3, RECV, 1, 0, 1, 64'hFFFF, 0);
    acc(3, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 64'h8, "R6 rejected clear had no effect", gotD, 64'h8);
  endtask

  task automatic tDir;
    acc(3, INVEC, 1, 1, 1, 0, 48'hABC0);
    chk(gotV && gotF == 1, "R7 write incoming", 64'(gotF), 1);
    chk(fsrValid && fsrAddr == 48'hABC0 && fsrWrite && fsrCtx == 0 && fsrCause == 1 && fsrSpace == INVEC,
        "R8 record on write fault", {fsrAddr, fsrSpace, 5'b0, fsrWrite, fsrCause}, {48'hABC0, INVEC, 5'b0, 1'b1, 2'd1});
    acc(3, DISP, 0, 1, 1, 0, 48'h5550);
    chk(gotV && gotF == 1 && gotD == 0, "R7 read dispatch", 64'(gotF), 1);
    chk(fsrValid && fsrAddr == 48'h5550 && !fsrWrite && fsrSpace == DISP,
        "R8 record on read fault", {fsrAddr, fsrSpace, 7'b0, fsrWrite}, {48'h5550, DISP, 8'b0});
    acc(3, RECV, 0, 1, 1, 0, 0);
    chk(gotD == 64'h8, "R7 rejected pop had no effect", gotD, 64'h8);
  endtask

  task automatic tOther;
    acc(3, 8'h55, 0, 1, 1, 0, 48'h9);
    chk(!gotV, "R10 foreign space no response", 64'(gotV), 0);
    chk(fsrAddr == 48'h5550, "R10 foreign space leaves record", 64'(fsrAddr), 64'h5550);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDispatchRead();
    tPop();
    tClear();
    tRange();
    tPriv();
    tDir();
    tOther();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule